// File: doc/BRIEF.md
# Four-Times Root-Raised-Cosine Interpolating Pulse Shaper

The block raises the rate of a 16-bit signed baseband sample stream by four and shapes it with a short root-raised-cosine response (roll-off 0.22, four output samples per symbol). The full prototype response is cut to its seven centre taps, and the resulting symmetric integers are 36, 79, 112, 128, 112, 79 and 36. The filter is polyphase. On every enabled clock one output phase is computed from at most two stored samples, so the zero samples that interpolation would insert are never multiplied. The products are built from shifts and adds of the constant bits. The taps that mirror each other share one product through a pre-add.

A upstream source drives a new sample on the first of every four enabled clocks. The downstream consumer takes one output word on each cycle where the valid strobe is high. The sum is kept at full precision. It is then scaled by 2^-7 with round-to-nearest and clamped to the 16-bit range.

Top module: `rrc_interp4`

## Requirements
- R1: While rst_n is low, dout is 0 and dout_vld is 0. Reset also clears the stored samples and the phase count, so the first enabled clock after reset is phase 0 and takes a fresh sample against a zero history.
- R2: dout_vld is high in exactly those cycles that follow a rising clock edge with ce high. dout takes its new value at that same edge.
- R3: While ce is low, dout keeps its value, dout_vld is low, and din has no effect on any later output.
- R4: Enabled clocks are counted modulo 4, starting at phase 0. din is captured only on phase 0. Its value on phases 1 to 3 has no effect.
- R5: Each output equals the full-precision sum over k = 0..6 of h[k]·u[n−k]. Here h = {36, 79, 112, 128, 112, 79, 36}, and u is the input stream with three zeros inserted after each sample. The phase-0 output already includes the sample captured at that edge.
- R6: The full-precision sum is scaled by adding 64 and shifting arithmetically right by 7. Ties therefore round toward plus infinity, so 4.5 gives 5 and −4.5 gives −4.
- R7: A scaled result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R8: A single sample A followed by zeros gives the seven outputs round(h[k]·A/128) in order k = 0..6, and zero after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable, one output per high cycle |
| din | input | 16 | Signed input sample, captured on phase 0 |
| dout | output | 16 | Registered signed filtered output |
| dout_vld | output | 1 | High for the cycle after each enabled edge |

## Verification
Small impulses of +16 and −16 give exact tie cases, which show whether the rounding goes upward and whether the taps come out in the right order. A larger impulse and a mid-scale step are compared against a zero-stuff-and-convolve model. They separate phase-selection errors from errors in the delay line. Full-scale steps and full-scale alternating input push the phase sums past the 16-bit range, so they check saturation in both directions and the cancellation that the shared pre-add produces. Garbage on din during phases 1 to 3, enable gaps with a changing din, and a reset in the middle of a run show that the input and the phase are taken only when they should be.

// File: rtl/rrc_interp4.sv
module rrc_interp4 #(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int SH = 7,
  parameter int C0 = 36,
  parameter int C1 = 79,
  parameter int C2 = 112,
  parameter int C3 = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout,
  output logic                 dout_vld
);
  localparam int AW = DW + CW + 2;
  localparam logic signed [AW-1:0] HALF = AW'(2 ** (SH - 1));
  localparam logic signed [AW-1:0] MAXV = AW'(2 ** (DW - 1) - 1);
  localparam logic signed [AW-1:0] MINV = AW'(-(2 ** (DW - 1)));

  logic [1:0]           phase;
  logic signed [DW-1:0] x0, x1;
  logic signed [DW-1:0] s0, s1;
  logic signed [AW-1:0] a, b, pair, acc, rnd, scl;
  logic signed [DW-1:0] ysat;
  logic                 ld;

  function automatic logic signed [AW-1:0] cmul(input logic signed [AW-1:0] v, input int c);
    logic signed [AW-1:0] r;
    r = '0;
    for (int i = 0; i < CW; i++)
      if (c[i]) r = r + (v <<< i);
    return r;
  endfunction

  assign ld   = (phase == 2'd0);
  assign s0   = ld ? din : x0;
  assign s1   = ld ? x0  : x1;
  assign a    = $signed({{(AW-DW){s0[DW-1]}}, s0});
  assign b    = $signed({{(AW-DW){s1[DW-1]}}, s1});
  assign pair = a + b;

  always_comb begin
    case (phase)
      2'd0:    acc = cmul(a, C0) + cmul(b, C2);
      2'd1:    acc = cmul(pair, C1);
      2'd2:    acc = cmul(a, C2) + cmul(b, C0);
      default: acc = cmul(a, C3);
    endcase
  end

  assign rnd  = acc + HALF;
  assign scl  = rnd >>> SH;
  assign ysat = (scl > MAXV) ? MAXV[DW-1:0] :
                (scl < MINV) ? MINV[DW-1:0] : scl[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      x0       <= '0;
      x1       <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= ce;
      if (ce) begin
        phase <= 2'(phase + 2'd1);
        dout  <= ysat;
        if (ld) begin
          x0 <= din;
          x1 <= x0;
        end
      end
    end
  end
endmodule

// File: rtl/rrc_interp4_chk.sv
module rrc_interp4_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce,
  input logic [DW-1:0] dout,
  input logic          dout_vld,
  input logic [1:0]    phase,
  input logic [DW-1:0] x0,
  input logic [DW-1:0] x1
);
  a_r2_vld_after_ce: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> dout_vld);

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(dout) && !dout_vld && $stable(x0) && $stable(x1) && $stable(phase)));

  a_r4_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (phase == 2'($past(phase) + 2'd1)));

  a_r4_line_only_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && phase != 2'd0) |=> ($stable(x0) && $stable(x1)));
endmodule

bind rrc_interp4 rrc_interp4_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .dout(dout), .dout_vld(dout_vld),
  .phase(phase), .x0(x0), .x1(x1)
);

// File: tb/sim_rrc_interp4.sv
`timescale 1ns/1ps
module sim_rrc_interp4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic signed [15:0] din = '0;
  logic signed [15:0] dout;
  logic dout_vld;

  int checks = 0;
  int failures = 0;
  int hm[7] = '{36, 79, 112, 128, 112, 79, 36};
  int u[7];
  int bph = 0;
  int lcg = 12345;

  always #5 clk = ~clk;

  rrc_interp4 u0 (.clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .dout(dout), .dout_vld(dout_vld));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_out();
    int s = 0;
    int r;
    for (int k = 0; k < 7; k++) s += hm[k] * u[k];
    r = (s + 64) >>> 7;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 7; k++) u[k] = 0;
    bph = 0;
  endtask

  // one enabled clock; v is driven on din whatever the phase
  task automatic tick(input string tag, input int v, output int got);
    int e;
    @(negedge clk);
    ce = 1'b1;
    din = 16'(v);
    for (int k = 6; k > 0; k--) u[k] = u[k-1];
    u[0] = (bph == 0) ? v : 0;
    bph = (bph + 1) % 4;
    e = model_out();
    @(posedge clk);
    #1;
    got = int'(dout);
    chk(tag, got, e);
    chk({tag, " R2 valid"}, int'(dout_vld), 1);
  endtask

  task automatic t_reset();
    chk("R1 reset dout", int'(dout), 0);
    chk("R1 reset vld", int'(dout_vld), 0);
  endtask

  task automatic t_round();
    int got;
    int pos[7] = '{5, 10, 14, 16, 14, 10, 5};
    int neg[7] = '{-4, -10, -14, -16, -14, -10, -4};
    for (int k = 0; k < 8; k++) begin
      tick("R6 tie pos", (k == 0) ? 16 : 0, got);
      if (k < 7) chk("R6 R8 pos explicit", got, pos[k]);
    end
    for (int k = 0; k < 8; k++) begin
      tick("R6 tie neg", (k == 0) ? -16 : 0, got);
      if (k < 7) chk("R6 R8 neg explicit", got, neg[k]);
    end
  endtask

  task automatic t_impulse();
    int got;
    for (int k = 0; k < 12; k++) tick("R8 R5 impulse", (k == 0) ? 1000 : 0, got);
    chk("R8 tail zero", got, 0);
  endtask

  task automatic t_step();
    int got;
    for (int k = 0; k < 16; k++) tick("R5 step", (k % 4 == 0) ? 10000 : 0, got);
  endtask

  task automatic t_sat();
    int got;
    for (int k = 0; k < 12; k++) tick("R7 sat high", (k % 4 == 0) ? 32767 : 0, got);
    chk("R7 clamp high", got, 32767);
    for (int k = 0; k < 12; k++) tick("R7 sat low", (k % 4 == 0) ? -32768 : 0, got);
    chk("R7 clamp low", got, -32768);
  endtask

  task automatic t_alt();
    int got;
    for (int k = 0; k < 24; k++)
      tick("R5 R7 alternating", (k % 4 == 0) ? (((k / 4) % 2 == 0) ? 32767 : -32768) : 0, got);
  endtask

  task automatic t_ignore();
    int got;
    for (int k = 0; k < 32; k++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      tick("R4 din ignored off phase 0", (lcg % 65536) - 32768, got);
    end
  endtask

  task automatic t_hold();
    int got;
    int held;
    tick("R3 pre-hold", 3000, got);
    held = got;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      ce = 1'b0;
      din = 16'(-20000 + k * 777);
      @(posedge clk);
      #1;
      chk("R3 hold dout", int'(dout), held);
      chk("R3 R2 vld low", int'(dout_vld), 0);
    end
    for (int k = 0; k < 10; k++) tick("R3 resume", (k == 3) ? -7000 : 0, got);
  endtask

  task automatic t_midreset();
    int got;
    tick("R1 pre-reset", 20000, got);
    tick("R1 pre-reset", 0, got);
    @(negedge clk);
    ce = 1'b0;
    rst_n = 1'b0;
    #2;
    chk("R1 async dout", int'(dout), 0);
    chk("R1 async vld", int'(dout_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    tick("R1 first after reset", 1000, got);
    chk("R1 phase0 fresh", got, 281);
    for (int k = 0; k < 4; k++) tick("R1 after reset", 0, got);
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_round();
    t_impulse();
    t_step();
    t_sat();
    t_alt();
    t_ignore();
    t_hold();
    t_midreset();
    @(negedge clk);
    ce = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule